// File: doc/BRIEF.md
# Memory error status capture unit

This block sits beside a memory controller's error-checking logic and keeps a record of memory errors that software can read. Each access that fails its check arrives as a one-cycle pulse on a single-bit or a multi-bit error input, together with the address of the access. The unit sets a sticky flag for each error class and stores the page number of the faulting access. The stored page belongs to the first error seen, except that an uncorrectable error may replace the page of a correctable one.

Software reaches the record through a small register port. Reads are combinational and writes take effect at the next clock edge. Flags are cleared by writing ones to them. Once both flags are clear, the next error records its page again. An optional non-maskable interrupt output reports uncorrectable errors as a level, for as long as the multi-bit flag stays set.

Top module: `mes_status_top`

## Requirements
- R1: After reset, STATUS (register address 0) reads 0, PAGE (address 1) reads 0, CONTROL (address 2) reads 0, and nmi_o is low.
- R2: A pulse on err_single_i sets STATUS bit 0 at the next clock edge. The bit stays set until software clears it.
- R3: A pulse on err_multi_i sets STATUS bit 1 at the next clock edge. The bit stays set until software clears it.
- R4: When both flags are clear, an error records its page as err_addr_i shifted right by PAGE_SHIFT (default 12, which gives 4 KiB pages). PAGE returns this value, zero-extended.
- R5: A single-bit error never changes PAGE while any flag is set. A multi-bit error never changes PAGE while the multi-bit flag is set.
- R6: A multi-bit error that arrives while only the single-bit flag is set replaces PAGE with its own page.
- R7: A write to STATUS clears bit 0 if data bit 0 is 1 and clears bit 1 if data bit 1 is 1. A data bit of 0 leaves its flag unchanged.
- R8: Once both flags have been cleared, the next error records its page again.
- R9: An error pulse in the same cycle as a write that clears its flag leaves that flag set. If the same write clears both flags, PAGE takes the page of the new error.
- R10: CONTROL bit 0 is a read/write interrupt enable. nmi_o is high exactly while the enable and STATUS bit 1 are both set.
- R11: A single-bit error never raises nmi_o.
- R12: Writes to PAGE have no effect. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_single_i | input | 1 | Pulse: correctable error on the current access |
| err_multi_i | input | 1 | Pulse: uncorrectable error on the current access |
| err_addr_i | input | ADDR_W | Address of the current access |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from reg_addr_i |
| nmi_o | output | 1 | Non-maskable interrupt level for uncorrectable errors |

## Verification
The assertions check on every cycle that the flags stay set, that an error always wins against a clear in the same cycle, that the page is frozen while a flag of equal or higher priority is set, that a first error records its page, and that the interrupt level holds until it is cleared or disabled. Only the bench scenarios show the register encodings as software sees them. These include the page shift on concrete addresses, the replacement of a single-bit page by a multi-bit page, re-arming after a full clear, and writes that must have no effect.

// File: rtl/mes_pkg.sv
package mes_pkg;
    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_STATUS = 2'd0,
        REG_PAGE   = 2'd1,
        REG_CTRL   = 2'd2,
        REG_RSVD   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic multi;
        logic single;
    } err_flags_t;

    localparam err_flags_t FLAGS_NONE = '{multi: 1'b0, single: 1'b0};

    function automatic logic any_flag(input err_flags_t f);
        return f.multi | f.single;
    endfunction
endpackage

// File: rtl/mes_capture.sv
module mes_capture
    import mes_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_s,
    input  logic              err_m,
    input  logic [ADDR_W-1:0] err_addr,
    input  err_flags_t        clr,
    output err_flags_t        flags_q,
    output logic [PAGE_W-1:0] page_q
);
    logic [PAGE_W-1:0] page_in;
    logic [PAGE_SHIFT-1:0] unused_offset;
    err_flags_t kept, flags_d;
    logic take_m, take_s;
    logic [PAGE_W-1:0] page_d;

    assign page_in       = err_addr[ADDR_W-1:PAGE_SHIFT];
    assign unused_offset = err_addr[PAGE_SHIFT-1:0];

    always_comb begin
        kept.single    = flags_q.single & ~clr.single;
        kept.multi     = flags_q.multi  & ~clr.multi;
        flags_d.single = kept.single | err_s;
        flags_d.multi  = kept.multi  | err_m;
        take_m = err_m & ~kept.multi;
        take_s = err_s & ~any_flag(kept);
        page_d = (take_m | take_s) ? page_in : page_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_NONE;
            page_q  <= '0;
        end else begin
            flags_q <= flags_d;
            page_q  <= page_d;
        end
    end

    a_r2_single_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags_q.single && !clr.single) |=> flags_q.single);
    a_r3_multi_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags_q.multi && !clr.multi) |=> flags_q.multi);
    a_r9_single_wins: assert property (@(posedge clk) disable iff (rst)
        err_s |=> flags_q.single);
    a_r9_multi_wins: assert property (@(posedge clk) disable iff (rst)
        err_m |=> flags_q.multi);
    a_r4_first_capture: assert property (@(posedge clk) disable iff (rst)
        (!flags_q.single && !flags_q.multi && (err_s || err_m))
        |=> page_q == $past(page_in));
    a_r5_hold_multi: assert property (@(posedge clk) disable iff (rst)
        (flags_q.multi && !clr.multi) |=> $stable(page_q));
    a_r5_hold_single: assert property (@(posedge clk) disable iff (rst)
        (flags_q.single && !clr.single && !err_m) |=> $stable(page_q));
endmodule

// File: rtl/mes_regs.sv
module mes_regs
    import mes_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  err_flags_t        flags,
    input  logic [PAGE_W-1:0] page,
    output err_flags_t        clr,
    output logic              nmi_en_q,
    output logic [DATA_W-1:0] reg_rdata
);
    reg_sel_e sel;
    logic wr_status, wr_ctrl;
    logic [DATA_W-3:0] unused_wdata;

    assign sel          = reg_sel_e'(reg_addr);
    assign wr_status    = reg_wr && (sel == REG_STATUS);
    assign wr_ctrl      = reg_wr && (sel == REG_CTRL);
    assign unused_wdata = reg_wdata[DATA_W-1:2];

    always_comb begin
        clr.single = wr_status & reg_wdata[0];
        clr.multi  = wr_status & reg_wdata[1];
    end

    always_ff @(posedge clk) begin
        if (rst)          nmi_en_q <= 1'b0;
        else if (wr_ctrl) nmi_en_q <= reg_wdata[0];
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_STATUS: reg_rdata = DATA_W'({flags.multi, flags.single});
            REG_PAGE:   reg_rdata = DATA_W'(page);
            REG_CTRL:   reg_rdata = DATA_W'(nmi_en_q);
            default:    reg_rdata = '0;
        endcase
    end

    a_r10_enable_write: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> nmi_en_q == $past(reg_wdata[0]));
    a_r10_enable_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(nmi_en_q));
endmodule

// File: rtl/mes_status_top.sv
module mes_status_top
    import mes_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_single_i,
    input  logic              err_multi_i,
    input  logic [ADDR_W-1:0] err_addr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              nmi_o
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

    err_flags_t        flags, clr;
    logic [PAGE_W-1:0] page;
    logic              nmi_en;

    mes_capture #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_cap (
        .clk(clk), .rst(rst),
        .err_s(err_single_i), .err_m(err_multi_i), .err_addr(err_addr_i),
        .clr(clr), .flags_q(flags), .page_q(page)
    );

    mes_regs #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr_i), .reg_wr(reg_wr_i), .reg_wdata(reg_wdata_i),
        .flags(flags), .page(page),
        .clr(clr), .nmi_en_q(nmi_en), .reg_rdata(reg_rdata_o)
    );

    assign nmi_o = flags.multi & nmi_en;

    a_r10_nmi_level: assert property (@(posedge clk) disable iff (rst)
        (nmi_o && !(reg_wr_i && reg_addr_i == 2'd0 && reg_wdata_i[1])
               && !(reg_wr_i && reg_addr_i == 2'd2 && !reg_wdata_i[0]))
        |=> nmi_o);
    a_r10_nmi_raise: assert property (@(posedge clk) disable iff (rst)
        (err_multi_i && nmi_en && !(reg_wr_i && reg_addr_i == 2'd2)) |=> nmi_o);
endmodule

// File: tb/sim_mes_status_top.sv
module sim_mes_status_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_single_i = 1'b0, err_multi_i = 1'b0;
    logic [31:0] err_addr_i = '0;
    logic [1:0]  reg_addr_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        nmi_o;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    mes_status_top u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic cycle(input logic s, input logic m, input logic [31:0] addr,
                         input logic wr, input logic [1:0] wa, input logic [31:0] wd);
        @(negedge clk);
        err_single_i = s; err_multi_i = m; err_addr_i = addr;
        reg_wr_i = wr; reg_addr_i = wa; reg_wdata_i = wd;
        @(negedge clk);
        err_single_i = 0; err_multi_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
    endtask

    task automatic err(input logic s, input logic m, input logic [31:0] addr);
        cycle(s, m, addr, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cycle(1'b0, 1'b0, 32'h0, 1'b1, a, d);
    endtask

    task automatic t_reset;
        chk_reg("R1 status", 2'd0, 0);
        chk_reg("R1 page", 2'd1, 0);
        chk_reg("R1 ctrl", 2'd2, 0);
        check("R1 nmi", nmi_o, 0);
    endtask

    task automatic t_single_first;
        err(1, 0, 32'h0003_4ABC);
        chk_reg("R2 single flag", 2'd0, 32'h1);
        chk_reg("R4 page capture", 2'd1, 32'h34);
        err(1, 0, 32'h9000_0000);
        chk_reg("R5 single no overwrite", 2'd1, 32'h34);
        repeat (3) @(negedge clk);
        chk_reg("R2 sticky", 2'd0, 32'h1);
    endtask

    task automatic t_multi_override;
        err(0, 1, 32'h0007_7000);
        chk_reg("R3 multi flag", 2'd0, 32'h3);
        chk_reg("R6 multi replaces page", 2'd1, 32'h77);
        err(0, 1, 32'h0008_8000);
        chk_reg("R5 multi no overwrite", 2'd1, 32'h77);
        err(1, 0, 32'h0009_9000);
        chk_reg("R5 single under multi", 2'd1, 32'h77);
    endtask

    task automatic t_clear;
        wr(2'd0, 32'h1);
        chk_reg("R7 clear single only", 2'd0, 32'h2);
        wr(2'd0, 32'h0);
        chk_reg("R7 zero write no effect", 2'd0, 32'h2);
        err(1, 0, 32'h000F_0000);
        chk_reg("R5 single while multi", 2'd1, 32'h77);
        wr(2'd0, 32'h3);
        chk_reg("R7 clear both", 2'd0, 32'h0);
        err(1, 0, 32'h000A_B000);
        chk_reg("R8 re-armed", 2'd1, 32'hAB);
        wr(2'd0, 32'h3);
    endtask

    task automatic t_nmi;
        wr(2'd2, 32'h1);
        chk_reg("R10 ctrl readback", 2'd2, 32'h1);
        err(1, 0, 32'h0000_1000);
        check("R11 single no nmi", nmi_o, 0);
        err(0, 1, 32'h0000_2000);
        check("R10 nmi raised", nmi_o, 1);
        repeat (5) @(negedge clk);
        check("R10 nmi level holds", nmi_o, 1);
        wr(2'd0, 32'h1);
        check("R10 nmi after single clear", nmi_o, 1);
        wr(2'd2, 32'h0);
        check("R10 nmi disabled", nmi_o, 0);
        wr(2'd2, 32'h1);
        check("R10 nmi re-enabled", nmi_o, 1);
        wr(2'd0, 32'h2);
        check("R10 nmi cleared", nmi_o, 0);
        wr(2'd2, 32'h0);
        err(0, 1, 32'h0000_3000);
        check("R10 nmi masked", nmi_o, 0);
        wr(2'd0, 32'h3);
    endtask

    task automatic t_collide;
        err(1, 0, 32'h0001_1000);
        cycle(1, 0, 32'h00CC_C000, 1'b1, 2'd0, 32'h3);
        chk_reg("R9 single wins clear", 2'd0, 32'h1);
        chk_reg("R9 page from new error", 2'd1, 32'hCCC);
        err(0, 1, 32'h00DD_D000);
        cycle(0, 1, 32'h00EE_E000, 1'b1, 2'd0, 32'h2);
        chk_reg("R9 multi wins clear", 2'd0, 32'h3);
        wr(2'd0, 32'h3);
    endtask

    task automatic t_ignored;
        err(1, 0, 32'h0005_5000);
        wr(2'd1, 32'hFFFF_FFFF);
        chk_reg("R12 page write ignored", 2'd1, 32'h55);
        chk_reg("R12 reserved reads zero", 2'd3, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_single_first;
        t_multi_override;
        t_clear;
        t_nmi;
        t_collide;
        t_ignored;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule